// File: doc/BRIEF.md
# Paired-Compare PWM Timer Channel

This block is one 16-bit timer channel with four compare registers and two output pins. A prescaler divides the system clock by a power of four and produces count ticks. A counter advances on each tick and returns to zero when it matches the compare register picked by the counter-clear field, so that register sets the period. In paired-compare PWM mode the pin-1 output is shaped by compares A and B, and the pin-2 output by compares C and D. Each compare event applies its own programmable output action.

Software configures the channel through a small register port and starts it with a run bit. While the channel is stopped, both pins are high-impedance. The block shows this as a low output-enable next to each pin's level.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset, both output enables are low and the mode, control, compare and run registers read back as 0.
- R2: Registers are written by `wr_en` with `addr`/`wdata`. The address map is 0 mode[3:0], 1 control[7:0], 2 A/B action byte, 3 C/D action byte, 4..7 compares A..D, 8 run bit 0, and 9 counter (read and write). A read with `rd_en` returns the value on `rdata` one clock later.
- R3: An action code has bits [1:0] as the match action (0 none/pin disabled, 1 drive low, 2 drive high, 3 toggle), bit 2 as the initial level, and bit 3 ignored. A pin's output enable is high one clock after the channel runs with a non-zero A (pin 1) or C (pin 2) action, and low one clock after it stops.
- R4: In mode 2 (paired), with clear-on-A (control bits [7:5] = 1), A code 2, B code 1 (B in the upper nibble of byte 2) and prescale 0, pin 1 repeats every A+1 clocks and stays high for B+1 clocks.
- R5: Clear code 5 clears the counter on a compare-C match. Pin 2, driven by the C (lower) and D (upper) nibbles of byte 3, then repeats every C+1 ticks.
- R6: Control bits [2:0] = n divide the count rate by 4^n. Values above 3 act as 3.
- R7: When the duty compare (B or D) is at or above its period compare (A or C), the duty action is suppressed and the pin keeps the level set by the period action.
- R8: In mode 0 (normal), the B and D actions are ignored, and each pin changes only on its A or C match.
- R9: A pin whose A or C action is 0 keeps its output enable low while the channel runs.
- R10: On a restart the pins resume their last level. If mode 0 was written while the channel was stopped, the next start loads each pin with the initial level of its A or C code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid one clock after `rd_en` |
| pin1_o | output | 1 | Pin 1 level (A/B pair) |
| pin1_oe | output | 1 | Pin 1 drive enable; low means high-impedance |
| pin2_o | output | 1 | Pin 2 level (C/D pair) |
| pin2_oe | output | 1 | Pin 2 drive enable; low means high-impedance |

## Verification
The hardest state to reach is the reinitialisation case. The bench has to show that a pin resumes a high level across a stop/start, and then drops to its initial low level once mode 0 has been written while stopped. To do this, the bench waits for a rising edge on pin 1 and stops the channel within the high phase. Because the stop lands before the duty match can pull the pin low, the retained level differs from the initial one. Changes of clear source are made with the channel stopped and the counter written to zero, so the counter never runs past a short period into a 65536-tick wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_MODE = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_IAB  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_ICD  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CA   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CB   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_CC   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CD   = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_RUN  = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 4'd9;

  localparam logic [3:0] MODE_NORMAL = 4'd0;
  localparam logic [3:0] MODE_PAIRED = 4'd2;
  localparam logic [2:0] CLR_ON_A    = 3'd1;
  localparam logic [2:0] CLR_ON_C    = 3'd5;

  // low two bits: match action; 0 also disables the pin
  function automatic logic act_enabled(input logic [2:0] code);
    return code[1:0] != 2'b00;
  endfunction

  function automatic logic act_initial(input logic [2:0] code);
    return code[2];
  endfunction

  function automatic logic act_apply(input logic [1:0] code, input logic cur);
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rdata,
  output logic              paired,
  output logic [2:0]        psc_sel,
  output logic [2:0]        clr_sel,
  output logic [2:0]        a_code,
  output logic [1:0]        b_code,
  output logic [2:0]        c_code,
  output logic [1:0]        d_code,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b,
  output logic [CNT_W-1:0]  cmp_c,
  output logic [CNT_W-1:0]  cmp_d,
  output logic              run,
  output logic              load_init,
  output logic              cnt_wr
);
  logic [3:0] mode_q;
  logic [7:0] ctrl_q, iab_q, icd_q;
  logic       reinit_q;
  logic       start_wr, norm_wr;

  assign start_wr  = wr_en && addr == ADR_RUN && wdata[0] && !run;
  assign norm_wr   = wr_en && addr == ADR_MODE && wdata[3:0] == MODE_NORMAL && !run;
  assign load_init = start_wr && reinit_q;
  assign cnt_wr    = wr_en && addr == ADR_CNT;

  assign paired  = mode_q == MODE_PAIRED;
  assign psc_sel = ctrl_q[2:0];
  assign clr_sel = ctrl_q[7:5];
  assign a_code  = iab_q[2:0];
  assign b_code  = iab_q[5:4];
  assign c_code  = icd_q[2:0];
  assign d_code  = icd_q[5:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; ctrl_q <= '0; iab_q <= '0; icd_q <= '0;
      cmp_a <= '0; cmp_b <= '0; cmp_c <= '0; cmp_d <= '0;
      run <= 1'b0; reinit_q <= 1'b1; rdata <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          ADR_MODE: mode_q <= wdata[3:0];
          ADR_CTRL: ctrl_q <= wdata[7:0];
          ADR_IAB:  iab_q  <= wdata[7:0];
          ADR_ICD:  icd_q  <= wdata[7:0];
          ADR_CA:   cmp_a  <= wdata;
          ADR_CB:   cmp_b  <= wdata;
          ADR_CC:   cmp_c  <= wdata;
          ADR_CD:   cmp_d  <= wdata;
          ADR_RUN:  run    <= wdata[0];
          default:  ;
        endcase
      end
      if (norm_wr)       reinit_q <= 1'b1;
      else if (start_wr) reinit_q <= 1'b0;
      if (rd_en) begin
        case (addr)
          ADR_MODE: rdata <= CNT_W'(mode_q);
          ADR_CTRL: rdata <= CNT_W'(ctrl_q);
          ADR_IAB:  rdata <= CNT_W'(iab_q);
          ADR_ICD:  rdata <= CNT_W'(icd_q);
          ADR_CA:   rdata <= cmp_a;
          ADR_CB:   rdata <= cmp_b;
          ADR_CC:   rdata <= cmp_c;
          ADR_CD:   rdata <= cmp_d;
          ADR_RUN:  rdata <= CNT_W'(run);
          ADR_CNT:  rdata <= cnt;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int MAX_SEL = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int PSC_W = 2 * MAX_SEL;
  logic [PSC_W-1:0] psc_q, lim;
  int               sel_c;

  always_comb begin
    sel_c = (int'(sel) > MAX_SEL) ? MAX_SEL : int'(sel);
    lim   = PSC_W'((1 << (2 * sel_c)) - 1);
  end

  assign tick = run && (psc_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) psc_q <= '0;
    else if (tick)   psc_q <= '0;
    else             psc_q <= psc_q + PSC_W'(1);
  end

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && lim != '0 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [2:0]       clr_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_c,
  output logic [CNT_W-1:0] cnt_q
);
  logic clr_hit;
  assign clr_hit = (clr_sel == CLR_ON_A && cnt_q == cmp_a) ||
                   (clr_sel == CLR_ON_C && cnt_q == cmp_c);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (tick) cnt_q <= clr_hit ? '0 : cnt_q + CNT_W'(1);
  end

  // R5
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && clr_hit && !ld) |=> cnt_q == '0);
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_hit && !ld) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_pin.sv
module pwm_pin
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             paired,
  input  logic             load_init,
  input  logic [2:0]       lead_code,
  input  logic [1:0]       trail_code,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] lead_cmp,
  input  logic [CNT_W-1:0] trail_cmp,
  output logic             pin_o,
  output logic             pin_oe
);
  logic full, hit_lead, hit_trail, mid, nxt;

  assign full      = trail_cmp >= lead_cmp;
  assign hit_lead  = tick && cnt == lead_cmp;
  assign hit_trail = tick && paired && !full && cnt == trail_cmp;

  always_comb begin
    mid = hit_lead  ? act_apply(lead_code[1:0], pin_o) : pin_o;
    nxt = hit_trail ? act_apply(trail_code, mid) : mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o  <= 1'b0;
      pin_oe <= 1'b0;
    end else begin
      pin_oe <= run && act_enabled(lead_code);
      pin_o  <= load_init ? act_initial(lead_code) : nxt;
    end
  end

  // R3
  stopped_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> !pin_oe);
  // R7
  full_duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && paired && full && !hit_lead && !load_init) |=> $stable(pin_o));
  // R8
  normal_ignores_trail_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !paired && !hit_lead && !load_init) |=> $stable(pin_o));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_SEL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              pin1_o,
  output logic              pin1_oe,
  output logic              pin2_o,
  output logic              pin2_oe
);
  localparam int NPIN = 2;

  logic             paired, run, load_init, cnt_wr, tick;
  logic [2:0]       psc_sel, clr_sel, a_code, c_code;
  logic [1:0]       b_code, d_code;
  logic [CNT_W-1:0] cmp_a, cmp_b, cmp_c, cmp_d, cnt;

  logic [2:0]       lead_code [NPIN];
  logic [1:0]       trail_code[NPIN];
  logic [CNT_W-1:0] lead_cmp  [NPIN];
  logic [CNT_W-1:0] trail_cmp [NPIN];
  logic [NPIN-1:0]  pin_o, pin_oe;

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .rdata(rdata), .paired(paired),
    .psc_sel(psc_sel), .clr_sel(clr_sel), .a_code(a_code), .b_code(b_code),
    .c_code(c_code), .d_code(d_code), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_c(cmp_c), .cmp_d(cmp_d), .run(run), .load_init(load_init),
    .cnt_wr(cnt_wr));

  pwm_prescale #(.MAX_SEL(MAX_SEL)) u_psc (
    .clk(clk), .rst(rst), .run(run), .sel(psc_sel), .tick(tick));

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .ld(cnt_wr), .ld_val(wdata),
    .clr_sel(clr_sel), .cmp_a(cmp_a), .cmp_c(cmp_c), .cnt_q(cnt));

  assign lead_code[0] = a_code;  assign trail_code[0] = b_code;
  assign lead_code[1] = c_code;  assign trail_code[1] = d_code;
  assign lead_cmp[0]  = cmp_a;   assign trail_cmp[0]  = cmp_b;
  assign lead_cmp[1]  = cmp_c;   assign trail_cmp[1]  = cmp_d;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    pwm_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst(rst), .run(run), .tick(tick), .paired(paired),
      .load_init(load_init), .lead_code(lead_code[g]),
      .trail_code(trail_code[g]), .cnt(cnt), .lead_cmp(lead_cmp[g]),
      .trail_cmp(trail_cmp[g]), .pin_o(pin_o[g]), .pin_oe(pin_oe[g]));
  end

  assign pin1_o  = pin_o[0];
  assign pin1_oe = pin_oe[0];
  assign pin2_o  = pin_o[1];
  assign pin2_oe = pin_oe[1];
endmodule

// File: tb/tb_pwm_pair_timer.sv
`timescale 1ns/1ps
module tb_pwm_pair_timer;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pin1_o, pin1_oe, pin2_o, pin2_oe;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  pwm_pair_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin1_o(pin1_o), .pin1_oe(pin1_oe),
    .pin2_o(pin2_o), .pin2_oe(pin2_oe));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic measure(input int which, input int n, output int highs, output int rises);
    logic prev, cur;
    highs = 0; rises = 0;
    @(negedge clk); prev = (which == 1) ? pin1_o : pin2_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cur = (which == 1) ? pin1_o : pin2_o;
      if (cur) highs++;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 pin1_oe", pin1_oe, 0);
    check("R1 pin2_oe", pin2_oe, 0);
    rd(4'd1, d); check("R1 ctrl", d, 0);
    rd(4'd4, d); check("R1 cmpA", d, 0);
    rd(4'd8, d); check("R1 run", d, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(4'd1, 16'h0020);
    rd(4'd1, d); check("R2 ctrl readback", d, 16'h20);
    wr(4'd4, 16'd9); wr(4'd5, 16'd3);
    rd(4'd5, d); check("R2 cmpB readback", d, 3);
    wr(4'd2, 16'h0012); wr(4'd3, 16'h0000); wr(4'd0, 16'd2);
    rd(4'd2, d); check("R2 A/B byte readback", d, 16'h12);
    repeat (3) @(negedge clk);
    check("R3 stopped pin1_oe", pin1_oe, 0);
  endtask

  task automatic t_paired();
    int h, r;
    wr(4'd8, 16'd1);
    repeat (25) @(negedge clk);
    check("R3 running pin1_oe", pin1_oe, 1);
    check("R9 code0 pin2_oe", pin2_oe, 0);
    measure(1, 40, h, r);
    check("R4 high clocks", h, 16);
    check("R4 periods", r, 4);
  endtask

  task automatic t_prescale();
    int h, r;
    wr(4'd1, 16'h0021);
    repeat (100) @(negedge clk);
    measure(1, 160, h, r);
    check("R6 high clocks /4", h, 64);
    check("R6 periods /4", r, 4);
    wr(4'd1, 16'h0020);
  endtask

  task automatic t_full();
    int h, r;
    wr(4'd5, 16'd12);
    repeat (30) @(negedge clk);
    measure(1, 30, h, r);
    check("R7 held high", h, 30);
    wr(4'd5, 16'd3);
  endtask

  task automatic t_clear_c();
    int h, r;
    wr(4'd8, 16'd0);
    wr(4'd3, 16'h0012); wr(4'd6, 16'd4); wr(4'd7, 16'd1);
    wr(4'd1, 16'h00A0); wr(4'd9, 16'd0);
    wr(4'd8, 16'd1);
    repeat (30) @(negedge clk);
    check("R5 pin2_oe", pin2_oe, 1);
    measure(2, 40, h, r);
    check("R5 high clocks", h, 16);
    check("R5 periods", r, 8);
    wr(4'd8, 16'd0); wr(4'd1, 16'h0020); wr(4'd9, 16'd0); wr(4'd8, 16'd1);
  endtask

  task automatic t_normal();
    int h, r;
    wr(4'd0, 16'd0);
    wr(4'd2, 16'h0013);
    repeat (40) @(negedge clk);
    measure(1, 40, h, r);
    check("R8 high clocks", h, 20);
    check("R8 periods", r, 2);
  endtask

  task automatic t_restart();
    logic prev;
    wr(4'd2, 16'h0012); wr(4'd0, 16'd2);
    prev = pin1_o;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pin1_o && !prev) break;
      prev = pin1_o;
    end
    wr(4'd8, 16'd0);
    repeat (2) @(negedge clk);
    check("R3 stop pin1_oe", pin1_oe, 0);
    check("R10 level kept while stopped", pin1_o, 1);
    wr(4'd8, 16'd1);
    check("R10 restart resumes level", pin1_o, 1);
    wr_en = 1'b1; addr = 4'd8; wdata = 16'd0;
    @(negedge clk); wr_en = 1'b0;
    wr(4'd0, 16'd0); wr(4'd0, 16'd2);
    wr(4'd8, 16'd1);
    check("R10 reinit to initial level", pin1_o, 0);
  endtask

  initial begin
    #1_200_000;
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_regs();
    t_paired();
    t_prescale();
    t_full();
    t_clear_c();
    t_normal();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule